// File: doc/BRIEF.md
# Link Self-Test Pattern Engine

This block is the self-test engine for an 8b/10b serial link. It sits between the user data path and the character encoder on the transmit side, and after the character decoder on the receive side. Each character on either side is 9 bits wide: an 8-bit data field and a flag that marks a special (control) character. In normal operation the transmit register passes user characters through. When the active-low test enable is driven low, that same register stops loading user data and instead steps as a 9-bit pseudo-random shift register. It emits a 511-character loop that starts with the data character D0.0.

The receive side has its own predictor of the same form. It hunts for the D0.0 loop marker. Once it has the marker it predicts every following character and compares the prediction with what arrives. It raises a one-character ready pulse each time a loop starts cleanly. It raises a one-character error pulse on each mismatch. If the marker is missing from its slot, it loses sync and hunts again. Releasing test enable returns both sides to normal data mode on the next character clock.

Top module: `lbist_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the transmit character becomes D0.0 (flag 0, data 0x00), both `loop_rdy_o` and `chk_err_o` become 0, and the checker enters its hunting state.
- R2: With `bist_n` high, the transmit character after each edge equals the {`tx_spec_i`, `tx_dat_i`} value sampled at that edge.
- R3: On the first edge with `bist_n` low, the transmit character becomes D0.0. On each further edge it advances. Writing the state as s = {flag, data} with the flag in bit 8, the next state is {s[7:0], ~(s[8] ^ s[4])}.
- R4: In test mode the transmit sequence repeats every 511 characters. One loop visits 511 distinct states: every value except flag 1 with data 0xFF. D0.0 appears once per loop.
- R5: In test mode the user inputs `tx_dat_i` and `tx_spec_i` have no effect on the transmit character.
- R6: When `bist_n` is high at an edge, the next transmit character is the user character, both status outputs are 0 one cycle later, and the checker returns to hunting.
- R7: While hunting, no character other than D0.0 produces either status pulse. A received D0.0 raises `loop_rdy_o` for one cycle after the edge that samples it, and the checker begins tracking.
- R8: While tracking, a received character that differs from the predicted one (outside the marker slot) raises `chk_err_o` for one cycle. Tracking continues with the next prediction.
- R9: When tracking, a D0.0 received in the marker slot raises `loop_rdy_o` for one cycle with no error.
- R10: When tracking, any other character received in the marker slot raises `chk_err_o` for one cycle without `loop_rdy_o`. The checker then drops sync and hunts.
- R11: `loop_rdy_o` and `chk_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_n | input | 1 | Test enable, active low |
| tx_dat_i | input | 8 | User transmit data field |
| tx_spec_i | input | 1 | User transmit special-character flag |
| tx_dat_o | output | 8 | Transmit data field to the encoder |
| tx_spec_o | output | 1 | Transmit special flag to the encoder |
| rx_dat_i | input | 8 | Received data field from the decoder |
| rx_spec_i | input | 1 | Received special flag from the decoder |
| loop_rdy_o | output | 1 | One-cycle pulse at each clean loop start |
| chk_err_o | output | 1 | One-cycle pulse on a mismatch |

## Verification
Two checker functions meet in the marker slot: the comparison that reports a mismatch, and the loss of sync that sends the checker back to hunting. The bench provokes both by corrupting a looped-back D0.0 exactly when the tracker expects it. It then expects a single error pulse with no ready pulse. After that it expects silence over the following characters, including deliberate corruptions, until the next marker restores a ready pulse. A stray D0.0 injected where a data character is predicted exercises the opposite overlap: the error path must win, and neither a ready pulse nor a resync may follow.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int DATA_W   = 8;
    localparam int CHAR_W   = DATA_W + 1;
    localparam int TAP_HI   = CHAR_W - 1;
    localparam int TAP_LO   = 4;
    localparam int LOOP_LEN = (1 << CHAR_W) - 1;

    typedef struct packed {
        logic              spec;
        logic [DATA_W-1:0] dat;
    } char_t;

    localparam char_t MARKER = '{spec: 1'b0, dat: '0};

    typedef enum logic {
        RX_HUNT  = 1'b0,
        RX_TRACK = 1'b1
    } rx_state_e;

    // XNOR feedback: the lock-up state is all ones, so all-zero (D0.0)
    // is a legal state and can serve as the loop start.
    function automatic char_t lfsr_step(input char_t c);
        logic [CHAR_W-1:0] s;
        s = c;
        return char_t'({s[CHAR_W-2:0], ~(s[TAP_HI] ^ s[TAP_LO])});
    endfunction

endpackage

// File: rtl/lbist_tx_gen.sv
module lbist_tx_gen
    import lbist_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  test_act,
    input  char_t usr_char,
    output char_t out_char
);

    char_t char_q;
    logic  run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            char_q <= MARKER;
            run_q  <= 1'b0;
        end else if (test_act) begin
            char_q <= run_q ? lfsr_step(char_q) : MARKER;
            run_q  <= 1'b1;
        end else begin
            char_q <= usr_char;
            run_q  <= 1'b0;
        end
    end

    assign out_char = char_q;

endmodule

// File: rtl/lbist_rx_chk.sv
module lbist_rx_chk
    import lbist_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  test_act,
    input  char_t rx_char,
    output logic  rdy,
    output logic  err
);

    rx_state_e state_q;
    char_t     pred_q;
    logic      rdy_q;
    logic      err_q;

    logic is_marker;
    logic slot_marker;
    logic hit;

    assign is_marker   = (rx_char == MARKER);
    assign slot_marker = (pred_q == MARKER);
    assign hit         = (rx_char == pred_q);

    always_ff @(posedge clk) begin
        if (rst || !test_act) begin
            state_q <= RX_HUNT;
            pred_q  <= MARKER;
            rdy_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            err_q <= 1'b0;
            unique case (state_q)
                RX_HUNT: begin
                    if (is_marker) begin
                        state_q <= RX_TRACK;
                        pred_q  <= lfsr_step(MARKER);
                        rdy_q   <= 1'b1;
                    end
                end
                RX_TRACK: begin
                    if (slot_marker) begin
                        if (is_marker) begin
                            rdy_q  <= 1'b1;
                            pred_q <= lfsr_step(MARKER);
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= RX_HUNT;
                        end
                    end else begin
                        err_q  <= !hit;
                        pred_q <= lfsr_step(pred_q);
                    end
                end
                default: state_q <= RX_HUNT;
            endcase
        end
    end

    assign rdy = rdy_q;
    assign err = err_q;

endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
    import lbist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bist_n,
    input  logic [DATA_W-1:0] tx_dat_i,
    input  logic              tx_spec_i,
    output logic [DATA_W-1:0] tx_dat_o,
    output logic              tx_spec_o,
    input  logic [DATA_W-1:0] rx_dat_i,
    input  logic              rx_spec_i,
    output logic              loop_rdy_o,
    output logic              chk_err_o
);

    logic  test_act;
    char_t usr_c;
    char_t out_c;
    char_t rx_c;

    assign test_act = !bist_n;
    assign usr_c    = '{spec: tx_spec_i, dat: tx_dat_i};
    assign rx_c     = '{spec: rx_spec_i, dat: rx_dat_i};

    lbist_tx_gen u_tx (
        .clk      (clk),
        .rst      (rst),
        .test_act (test_act),
        .usr_char (usr_c),
        .out_char (out_c)
    );

    lbist_rx_chk u_rx (
        .clk      (clk),
        .rst      (rst),
        .test_act (test_act),
        .rx_char  (rx_c),
        .rdy      (loop_rdy_o),
        .err      (chk_err_o)
    );

    assign tx_dat_o  = out_c.dat;
    assign tx_spec_o = out_c.spec;

endmodule

// File: rtl/lbist_engine_chk.sv
module lbist_engine_chk
    import lbist_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bist_n,
    input logic [DATA_W-1:0] tx_dat_i,
    input logic              tx_spec_i,
    input logic [DATA_W-1:0] tx_dat_o,
    input logic              tx_spec_o,
    input logic [DATA_W-1:0] rx_dat_i,
    input logic              rx_spec_i,
    input logic              loop_rdy_o,
    input logic              chk_err_o
);

    char_t cur_c;
    char_t usr_c;
    char_t rx_c;
    assign cur_c = '{spec: tx_spec_o, dat: tx_dat_o};
    assign usr_c = '{spec: tx_spec_i, dat: tx_dat_i};
    assign rx_c  = '{spec: rx_spec_i, dat: rx_dat_i};

    a_r2_user_pass: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bist_n)) |-> (cur_c == $past(usr_c)));

    a_r3_marker_first: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bist_n) && $past(bist_n, 2)) |-> (cur_c == MARKER));

    a_r3_lfsr_advance: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(bist_n) && !$past(bist_n, 2))
        |-> (cur_c == lfsr_step($past(cur_c))));

    a_r6_quiet_off: assert property (@(posedge clk) disable iff (rst)
        $past(bist_n) |-> (!loop_rdy_o && !chk_err_o));

    a_r9_rdy_after_marker: assert property (@(posedge clk) disable iff (rst)
        loop_rdy_o |-> ($past(rx_c) == MARKER));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(loop_rdy_o && chk_err_o));

endmodule

bind lbist_engine lbist_engine_chk u_chk (.*);

// File: tb/lbist_engine_bench.sv
module lbist_engine_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bist_n = 1'b1;
    logic [7:0] tx_dat_i = '0;
    logic       tx_spec_i = 1'b0;
    logic [7:0] tx_dat_o;
    logic       tx_spec_o;
    logic [7:0] rx_dat_i = 8'h55;
    logic       rx_spec_i = 1'b1;
    logic       loop_rdy_o;
    logic       chk_err_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lbist_engine u_lbist_engine (
        .clk        (clk),
        .rst        (rst),
        .bist_n     (bist_n),
        .tx_dat_i   (tx_dat_i),
        .tx_spec_i  (tx_spec_i),
        .tx_dat_o   (tx_dat_o),
        .tx_spec_o  (tx_spec_o),
        .rx_dat_i   (rx_dat_i),
        .rx_spec_i  (rx_spec_i),
        .loop_rdy_o (loop_rdy_o),
        .chk_err_o  (chk_err_o)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Bench-side model, built from the requirements.
    logic [8:0] m_tx;
    bit         m_run;
    bit         m_hunt;
    logic [8:0] m_pred;

    function automatic logic [8:0] nxt(input logic [8:0] s);
        return {s[7:0], ~(s[8] ^ s[4])};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [8:0] tx_now();
        return {tx_spec_o, tx_dat_o};
    endfunction

    // One character clock: drive, predict, clock, compare.
    task automatic cyc(input bit act_n, input logic [8:0] usr,
                       input logic [8:0] rxv, input string req);
        bit er, ee;
        er = 0; ee = 0;
        bist_n    = act_n;
        {tx_spec_i, tx_dat_i} = usr;
        {rx_spec_i, rx_dat_i} = rxv;
        if (!act_n) begin
            m_tx  = m_run ? nxt(m_tx) : 9'h000;
            m_run = 1;
            if (m_hunt) begin
                if (rxv == 9'h000) begin
                    m_hunt = 0; m_pred = nxt(9'h000); er = 1;
                end
            end else if (m_pred == 9'h000) begin
                if (rxv == 9'h000) begin
                    er = 1; m_pred = nxt(9'h000);
                end else begin
                    ee = 1; m_hunt = 1;
                end
            end else begin
                ee = (rxv != m_pred);
                m_pred = nxt(m_pred);
            end
        end else begin
            m_tx = usr; m_run = 0; m_hunt = 1;
        end
        @(posedge clk); #1;
        check(req, "tx char", 32'(tx_now()), 32'(m_tx));
        check(req, "loop_rdy", 32'(loop_rdy_o), 32'(er));
        check(req, "chk_err", 32'(chk_err_o), 32'(ee));
        check("R11", "rdy&err", 32'(loop_rdy_o & chk_err_o), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        bit seen [512];
        int distinct;
        int markers;
        bit hit_marker_slot;
        logic [8:0] cur;
        logic [8:0] v;
        void'($urandom(32'd20240607));

        // R1: reset state
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "tx char", 32'(tx_now()), 32'h000);
        check("R1", "loop_rdy", 32'(loop_rdy_o), 32'd0);
        check("R1", "chk_err", 32'(chk_err_o), 32'd0);
        m_tx = 9'h000; m_run = 0; m_hunt = 1; m_pred = 9'h000;
        rst = 1'b0;

        // R2 / R6: normal mode, random users chars, receiver must stay quiet
        for (int i = 0; i < 24; i++) begin
            v = (i % 5 == 0) ? 9'h000 : 9'($urandom);
            cyc(1'b1, 9'($urandom), v, "R2");
        end

        // R3: entry, first character is the marker
        cyc(1'b0, 9'($urandom), 9'h155, "R3");
        for (int i = 0; i < 512; i++) seen[i] = 0;
        seen[tx_now()] = 1;
        markers = (tx_now() == 9'h000) ? 1 : 0;
        distinct = 1;

        // R4 / R5 / R9: loopback, random user inputs ignored
        for (int i = 1; i <= 1100; i++) begin
            cyc(1'b0, 9'($urandom), tx_now(), (i % 2) ? "R5" : "R9");
            cur = tx_now();
            if (i < 511 && !seen[cur]) begin
                seen[cur] = 1; distinct++;
            end
            if (cur == 9'h000) markers++;
        end
        check("R4", "distinct states per loop", 32'(distinct), 32'd511);
        check("R4", "lock-up state visited", 32'(seen[9'h1FF]), 32'd0);
        check("R4", "markers in 1101 chars", 32'(markers), 32'd3);

        // R8: stray marker where a data character is predicted
        while (tx_now() == 9'h000 || nxt(tx_now()) == 9'h000)
            cyc(1'b0, 9'h000, tx_now(), "R9");
        cyc(1'b0, 9'h000, 9'h000, "R8");
        cyc(1'b0, 9'h000, tx_now(), "R8");

        // R7 / R8 / R10: random corruption plus a corrupted marker slot
        hit_marker_slot = 0;
        for (int i = 0; i < 1600; i++) begin
            cur = tx_now();
            if (cur == 9'h000 && !hit_marker_slot) begin
                hit_marker_slot = 1;
                cyc(1'b0, 9'($urandom), 9'h0AA, "R10");
            end else if (($urandom % 30) == 0) begin
                cyc(1'b0, 9'($urandom), cur ^ 9'h008, m_hunt ? "R7" : "R8");
            end else begin
                cyc(1'b0, 9'($urandom), cur, m_hunt ? "R7" : "R9");
            end
        end

        // R6: leave test mode, then R3 again on re-entry
        cyc(1'b1, 9'h0C3, 9'h000, "R6");
        cyc(1'b1, 9'h1A5, 9'h000, "R6");
        cyc(1'b0, 9'h0C3, 9'h155, "R3");
        cyc(1'b0, 9'h0C3, tx_now(), "R7");
        cyc(1'b0, 9'h0C3, tx_now(), "R3");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule